// File: doc/BRIEF.md
# Glitch-Free Four-Source Clock Selector

This block hands one output clock to whichever of four free-running source clocks a 2-bit select names. The source frequencies are fixed when the chip is built; only the choice among them changes while it runs. A voltage/frequency controller uses it to move a domain between operating points. Source 0 is the fastest clock, and the others run at 0.9, 0.8 and 0.6 of its rate.

Each source has its own lane. A lane holds an enable flop that changes on that source's falling edge, and it has two-flop synchronizers clocked by that source. A lane turns on only after it has seen every other lane's enable low. The output is the OR of the four gated lanes, so the clock tree needs a single buffer and no cascade of 2:1 stages. Source 0 also clocks a small control register. That register takes a new selection only after the previous switch has fully settled.

A separate freeze input stops the output clock, for example while the supply voltage is moving. The output is parked low after the current high phase ends, and it restarts cleanly when freeze is released. The reset deassertion is assumed to be synchronized to the sources outside this block.

Top module: `glitchless_clk_mux`

## Requirements
- R1: While rst_n is low, clk_out shows no rising edge. After reset is released, clk_out runs at the period of source 0 (10 ns in the bench) without any select change.
- R2: Once a switch has settled, every interval between rising edges of clk_out equals the period of the selected source.
- R3: No glitch: a lane enable changes only while its own source is low. Every high pulse of clk_out lasts at least half the period of the fastest source. clk_out rises only while exactly one lane is enabled.
- R4: For every ordered pair of distinct sources, the rising-edge interval that spans a switch is at least the period of the slower of the old and new source.
- R5: At most one lane enable is high at any time, so a settled output matches exactly one source period.
- R6: While freeze is high, clk_out is held low once the high phase in progress has finished. After freeze falls, clk_out resumes at the selected source's period.
- R7: A select value that arrives while a switch is still in progress is applied only after that switch completes. An intermediate selection that was accepted therefore drives clk_out for some cycles before the later one takes over.
- R8: A select change made while freeze is high produces no edge on clk_out. The new source is the one that runs when freeze falls.
- R9: Encoding: sel = k (0 to 3) picks clk_in[k]. clk_in[0] must be the fastest source and always running, because it also clocks the selection register. A new sel value is accepted only after two equal consecutive synchronized samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 4 | Free-running source clocks; bit k is source k, bit 0 the fastest |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 2 | Requested source index, asynchronous to all sources |
| freeze | input | 1 | When high, parks clk_out low after the current high phase |
| clk_out | output | 1 | Selected, gated output clock |

## Verification
The checker watches the structural safety of the gating on every cycle and every edge. It checks that at most one lane is enabled and at most one lane is requested, and that each enable moves only while its own source is low. It checks that clk_out rises only with a single lane enabled, and that the selection register moves only after the synchronized enables match the request. What only the bench scenarios can show is timing at the output. That covers the settled period after each switch, the interval across each of the twelve source-to-destination switches, the parked output under freeze, a select changed while frozen, and a selection deferred behind a switch in progress. The bench measures these from clk_out edges in real time.

// File: rtl/clkmux_pkg.sv
`timescale 1ns/1ps
package clkmux_pkg;

    localparam int unsigned SRC_N = 4;
    localparam int unsigned SEL_W = $clog2(SRC_N);

    typedef logic [SRC_N-1:0] src_vec_t;
    typedef logic [SEL_W-1:0] src_sel_t;

    // selection register state, clocked by source 0
    typedef struct packed {
        src_sel_t cur;       // accepted source index
        src_sel_t sel_last;  // previous synchronized select sample
        src_vec_t go;        // one-hot run request to the lanes
    } ctrl_state_t;

    // per-lane state, clocked on the falling edge of the lane source
    typedef struct packed {
        logic en;
    } lane_state_t;

    function automatic src_vec_t sel_to_vec(input src_sel_t s);
        src_vec_t v;
        v = '0;
        v[s] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/cmx_sync.sv
`timescale 1ns/1ps
module cmx_sync #(
    parameter int unsigned WIDTH   = 1,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] pipe_d;
    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    always_comb begin
        pipe_d[0] = d;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= {STAGES{RST_VAL}};
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/cmx_ctrl.sv
`timescale 1ns/1ps
module cmx_ctrl
    import clkmux_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  src_sel_t sel_in,
    input  logic     freeze_in,
    input  src_vec_t lane_en_in,
    output src_vec_t go_vec,
    output src_sel_t cur_sel,
    output src_vec_t en_seen
);

    src_sel_t    sel_s;
    logic        frz_s;
    ctrl_state_t st_d;
    ctrl_state_t st_q;
    logic        settled;

    cmx_sync #(.WIDTH(SEL_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sel_sync (
        .clk(clk), .rst_n(rst_n), .d(sel_in), .q(sel_s)
    );

    cmx_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_frz_sync (
        .clk(clk), .rst_n(rst_n), .d(freeze_in), .q(frz_s)
    );

    cmx_sync #(.WIDTH(SRC_N), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_en_sync (
        .clk(clk), .rst_n(rst_n), .d(lane_en_in), .q(en_seen)
    );

    always_comb begin
        st_d          = st_q;
        st_d.sel_last = sel_s;
        // lanes agree with the request: no switch in flight
        settled = (en_seen == st_q.go);
        // a multi-bit select is taken only once two samples agree
        if (settled && (sel_s == st_q.sel_last)) begin
            st_d.cur = sel_s;
        end
        st_d.go = frz_s ? '0 : sel_to_vec(st_d.cur);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cur: '0, sel_last: '0, go: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign go_vec  = st_q.go;
    assign cur_sel = st_q.cur;

endmodule

// File: rtl/cmx_lane.sv
`timescale 1ns/1ps
module cmx_lane
    import clkmux_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_src,
    input  logic rst_n,
    input  logic run_req,
    input  logic others_on,
    output logic en_out,
    output logic clk_gated
);

    logic [1:0]  req_s;
    logic        want_s;
    logic        busy_s;
    lane_state_t st_d;
    lane_state_t st_q;

    cmx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_req_sync (
        .clk(clk_src), .rst_n(rst_n), .d({run_req, others_on}), .q(req_s)
    );

    assign want_s = req_s[1];
    assign busy_s = req_s[0];

    always_comb begin
        st_d    = st_q;
        st_d.en = want_s & ~busy_s;
    end

    // falling edge: the enable only moves while the source is low
    always_ff @(negedge clk_src or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{en: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign en_out    = st_q.en;
    assign clk_gated = clk_src & st_q.en;

endmodule

// File: rtl/glitchless_clk_mux.sv
`timescale 1ns/1ps
module glitchless_clk_mux
    import clkmux_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic [3:0] clk_in,
    input  logic       rst_n,
    input  logic [1:0] sel,
    input  logic       freeze,
    output logic       clk_out
);

    src_vec_t go_vec;
    src_sel_t cur_sel;
    src_vec_t en_seen;
    src_vec_t lane_en;
    src_vec_t lane_busy;
    src_vec_t gated;

    cmx_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
        .clk(clk_in[0]),
        .rst_n(rst_n),
        .sel_in(sel),
        .freeze_in(freeze),
        .lane_en_in(lane_en),
        .go_vec(go_vec),
        .cur_sel(cur_sel),
        .en_seen(en_seen)
    );

    for (genvar g = 0; g < SRC_N; g++) begin : g_lane
        localparam src_vec_t SELF = src_vec_t'(1) << g;

        assign lane_busy[g] = |(lane_en & ~SELF);

        cmx_lane #(.SYNC_STAGES(SYNC_STAGES)) u_lane (
            .clk_src(clk_in[g]),
            .rst_n(rst_n),
            .run_req(go_vec[g]),
            .others_on(lane_busy[g]),
            .en_out(lane_en[g]),
            .clk_gated(gated[g])
        );
    end

    assign clk_out = |gated;

endmodule

// File: rtl/clk_mux_chk.sv
`timescale 1ns/1ps
module clk_mux_chk
    import clkmux_pkg::*;
(
    input logic [3:0] clk_src,
    input logic       rst_n,
    input logic       clk_out,
    input src_vec_t   lane_en,
    input src_vec_t   go_vec,
    input src_sel_t   cur_sel,
    input src_vec_t   en_seen
);

    // R5
    one_lane_chk: assert property (@(posedge clk_src[0]) disable iff (!rst_n)
        $onehot0(lane_en));

    // R5
    one_req_chk: assert property (@(posedge clk_src[0]) disable iff (!rst_n)
        $onehot0(go_vec));

    // R7
    defer_sel_chk: assert property (@(posedge clk_src[0]) disable iff (!rst_n)
        !$stable(cur_sel) |-> $past(en_seen == go_vec));

    // R3
    always @(posedge clk_out) begin
        if (rst_n) begin
            out_rise_chk: assert ($onehot(lane_en));
        end
    end

    for (genvar g = 0; g < SRC_N; g++) begin : g_edge
        // R3
        always @(lane_en[g]) begin
            if (rst_n) begin
                en_low_phase_chk: assert (clk_src[g] == 1'b0);
            end
        end
    end

endmodule

bind glitchless_clk_mux clk_mux_chk u_chk (
    .clk_src(clk_in),
    .rst_n(rst_n),
    .clk_out(clk_out),
    .lane_en(lane_en),
    .go_vec(go_vec),
    .cur_sel(cur_sel),
    .en_seen(en_seen)
);

// File: tb/sim_glitchless_clk_mux.sv
`timescale 1ns/1ps
module sim_glitchless_clk_mux;

    logic       tb_clk = 1'b0;
    logic       c0 = 1'b0;
    logic       c1 = 1'b0;
    logic       c2 = 1'b0;
    logic       c3 = 1'b0;
    logic [3:0] clk_in;
    logic       rst_n = 1'b0;
    logic [1:0] sel = 2'd0;
    logic       freeze = 1'b0;
    logic       clk_out;

    assign clk_in = {c3, c2, c1, c0};

    always #10 tb_clk = ~tb_clk;
    always #5.0   c0 = ~c0;
    always #5.556 c1 = ~c1;
    always #6.25  c2 = ~c2;
    always #8.333 c3 = ~c3;

    glitchless_clk_mux u0 (
        .clk_in(clk_in),
        .rst_n(rst_n),
        .sel(sel),
        .freeze(freeze),
        .clk_out(clk_out)
    );

    real     per [4] = '{10.0, 11.112, 12.5, 16.666};
    int      checks = 0;
    int      fails = 0;
    int      rise_cnt = 0;
    int      hist [4] = '{0, 0, 0, 0};
    realtime last_rise = 0;
    bit      have_last = 1'b0;
    bit      sw_arm = 1'b0;
    int      sw_old = 0;
    real     floor_v = 0.0;
    int      cur_k = 0;
    real     exp_q [$];
    string   tag_q [$];

    function automatic real absr(input real x);
        return (x < 0.0) ? -x : x;
    endfunction

    function automatic real maxr(input real a, input real b);
        return (a > b) ? a : b;
    endfunction

    task automatic chk(input bit ok, input string tag, input real act, input real exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0.3f expected=%0.3f", tag, act, exp);
        end
    endtask

    // monitor: scoreboard side, measures clk_out edges
    always @(posedge clk_out) begin
        realtime now;
        real     iv;
        real     e;
        string   t;
        now = $realtime;
        rise_cnt++;
        if (have_last) begin
            iv = now - last_rise;
            for (int k = 0; k < 4; k++) begin
                if (absr(iv - per[k]) < 0.05) hist[k]++;
            end
            chk(iv >= per[0] - 0.05, "R3 interval shorter than fastest source", iv, per[0]);
            if (sw_arm && absr(iv - per[sw_old]) >= 0.05) begin
                chk(iv >= floor_v - 0.05, "R4 switch interval", iv, floor_v);
                sw_arm = 1'b0;
            end
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(absr(iv - e) < 0.05, t, iv, e);
            end
        end
        last_rise = now;
        have_last = 1'b1;
    end

    always @(negedge clk_out) begin
        real hw;
        if (have_last) begin
            hw = $realtime - last_rise;
            chk(hw >= 4.9, "R3 high pulse width", hw, 5.0);
        end
    end

    // driver side
    task automatic settle();
        repeat (40) @(posedge tb_clk);
    endtask

    task automatic expect_period(input int k, input string tag);
        exp_q.push_back(per[k]);
        tag_q.push_back(tag);
        while (exp_q.size() != 0) @(negedge tb_clk);
    endtask

    task automatic switch_to(input int k);
        @(negedge tb_clk);
        sw_old  = cur_k;
        floor_v = maxr(per[cur_k], per[k]);
        sw_arm  = 1'b1;
        sel     = 2'(k);
        settle();
        chk(sw_arm == 1'b0, "R4 transition interval observed", real'(sw_arm), 0.0);
        cur_k = k;
        expect_period(k, "R2 R5 settled period");
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (10) @(posedge tb_clk);
        // R1: no edge during reset
        chk(rise_cnt == 0, "R1 rises during reset", real'(rise_cnt), 0.0);
        chk(clk_out == 1'b0, "R1 output low in reset", real'(clk_out), 0.0);
        @(negedge tb_clk);
        rst_n = 1'b1;
        settle();
        // R1 R9: source 0 after reset
        expect_period(0, "R1 R9 period after reset");
        cur_k = 0;

        // R4: all twelve ordered pairs
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                if (a != b) begin
                    if (cur_k != a) switch_to(a);
                    switch_to(b);
                end
            end
        end

        // R6: freeze parks the output low
        @(negedge tb_clk);
        freeze = 1'b1;
        repeat (10) @(posedge tb_clk);
        begin
            int n0;
            n0 = rise_cnt;
            repeat (20) @(posedge tb_clk);
            chk(rise_cnt == n0, "R6 rises while frozen", real'(rise_cnt - n0), 0.0);
        end
        @(negedge tb_clk);
        chk(clk_out == 1'b0, "R6 output level while frozen", real'(clk_out), 0.0);
        freeze = 1'b0;
        settle();
        expect_period(cur_k, "R6 period after release");

        // R8: select moved while frozen
        @(negedge tb_clk);
        freeze = 1'b1;
        settle();
        begin
            int n1;
            n1 = rise_cnt;
            @(negedge tb_clk);
            sel = 2'd0;
            settle();
            chk(rise_cnt == n1, "R8 rises on select change while frozen", real'(rise_cnt - n1), 0.0);
        end
        @(negedge tb_clk);
        freeze = 1'b0;
        settle();
        cur_k = 0;
        expect_period(0, "R8 new source after release");

        // R7: selection changed while a switch is in flight
        @(negedge tb_clk);
        for (int k = 0; k < 4; k++) hist[k] = 0;
        sw_old  = 0;
        floor_v = maxr(per[0], per[1]);
        sw_arm  = 1'b1;
        sel     = 2'd1;
        repeat (2) @(negedge tb_clk);
        sel = 2'd2;
        settle();
        chk(hist[1] > 0, "R7 intermediate source ran", real'(hist[1]), 1.0);
        chk(sw_arm == 1'b0, "R7 R4 transition interval observed", real'(sw_arm), 0.0);
        cur_k = 2;
        expect_period(2, "R7 final source period");

        finish_run();
    end

    initial begin
        repeat (150000) @(posedge tb_clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

endmodule